// File: doc/BRIEF.md
# Zero-Wait-State Fetch-Execute Sequencer

This block is the control sequencer of a small processor that runs every instruction as a fixed train of five microcycles on one byte-wide synchronous system bus. It keeps an instruction pointer, an opcode register, a memory address register, two operand latches and a 16-bit accumulator. Each microcycle lasts exactly one clock and is either one bus transfer or an idle slot. The bus has no ready or acknowledge line. The memory must present read data before the rising edge that closes the microcycle. Whatever value is on the bus at that edge is taken as valid, so a memory that answers late corrupts the result without any warning.

Three opcodes do work: a load of a 16-bit immediate into the accumulator, an add from one memory byte that stores the result to a second address, and an add through a pointer held in memory that stores the result back in place. Every other opcode is a one-byte no-operation. A debug output shows the current microcycle number.

Top module: `fx_sequencer`

## Requirements
- R1: A synchronous active-low reset makes the instruction pointer 0, the accumulator 0 and the microcycle 0. The first fetch after reset reads address 0.
- R2: `phase_o` steps 0, 1, 2, 3, 4 and then returns to 0, advancing by one on every clock. No microcycle is skipped or repeated.
- R3: Microcycle 0 is a read (`bus_act`=1, `bus_rw`=1) at the instruction pointer. The byte present at the end of that clock becomes the opcode.
- R4: Opcode 0xB8 is followed by an immediate stored low byte first and high byte second. Microcycles 1 and 2 read those bytes at IP+1 and IP+2, microcycles 3 and 4 are idle, and the accumulator becomes {high, low} when microcycle 3 ends.
- R5: Opcode 0x01 is followed by a source address byte and a destination address byte. Microcycles 1 and 2 read those bytes, microcycle 3 reads the source, and the accumulator becomes (accumulator + source byte) mod 2^16. Microcycle 4 writes the new low accumulator byte to the destination.
- R6: Opcode 0x03 is followed by one pointer byte P. Microcycle 1 reads P at IP+1, microcycle 2 reads address A from P, and microcycle 3 reads the operand from A and adds it to the accumulator. Microcycle 4 writes the new low accumulator byte back to A.
- R7: At the end of microcycle 4 the instruction pointer advances by the instruction length and wraps modulo 2^ADDR_W. The length is 3 for 0xB8 and 0x01, 2 for 0x03 and 1 for any other opcode. The pointer holds its value in all other microcycles.
- R8: Any opcode other than 0xB8, 0x01 and 0x03 leaves the accumulator unchanged and keeps `bus_act` at 0 in microcycles 1 to 4.
- R9: A write (`bus_act`=1, `bus_rw`=0) occurs only in microcycle 4. Every other active cycle is a read whose data is taken at the rising edge that ends that same microcycle, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rdata | input | 8 | Read data from memory, valid by the end of the cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Write data, the low accumulator byte |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_act | output | 1 | 1 = this microcycle carries a bus transfer |
| acc_o | output | 16 | Accumulator |
| phase_o | output | 3 | Current microcycle number 0..4 |

## Verification
The bus outputs of a microcycle come from registers loaded at the previous rising edge. The bench therefore reads address, direction and write data at the falling edge inside each microcycle, and the memory model answers combinationally in that same cycle. A read's effect shows one edge later: the accumulator result of microcycle 3 is checked at the falling edge of microcycle 4 or later. The new instruction pointer is checked as the fetch address one edge after microcycle 4. The sweeps cover every opcode value and enough instructions to wrap the instruction pointer several times. A reset applied in the middle of an instruction is checked one edge after it is sampled.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = 2 * BYTE_W;
  localparam int NUM_PH = 5;
  localparam int PH_W   = 3;

  localparam logic [BYTE_W-1:0] OPC_LDI  = 8'hB8;
  localparam logic [BYTE_W-1:0] OPC_ADDM = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_IND  = 8'h03;

  localparam logic [PH_W-1:0] PH_FETCH = 3'd0;
  localparam logic [PH_W-1:0] PH_ARG1  = 3'd1;
  localparam logic [PH_W-1:0] PH_ARG2  = 3'd2;
  localparam logic [PH_W-1:0] PH_EXEC  = 3'd3;
  localparam logic [PH_W-1:0] PH_STORE = 3'd4;

  typedef enum logic [1:0] {
    K_NOP  = 2'd0,
    K_LDI  = 2'd1,
    K_ADDM = 2'd2,
    K_IND  = 2'd3
  } kind_e;

  function automatic kind_e kind_of(input logic [BYTE_W-1:0] op);
    case (op)
      OPC_LDI:  return K_LDI;
      OPC_ADDM: return K_ADDM;
      OPC_IND:  return K_IND;
      default:  return K_NOP;
    endcase
  endfunction

  function automatic logic [1:0] len_of(input kind_e k);
    case (k)
      K_LDI, K_ADDM: return 2'd3;
      K_IND:         return 2'd2;
      default:       return 2'd1;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] acc_add(input logic [ACC_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    return a + {{(ACC_W-BYTE_W){1'b0}}, b};
  endfunction

  function automatic logic [ACC_W-1:0] imm_join(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/fx_phase_ctr.sv
module fx_phase_ctr
  import fx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            last_phase
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_PH - 1);

  logic [PH_W-1:0] phase_q;

  assign last_phase = (phase_q == PH_LAST);
  assign phase      = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= '0;
    else if (last_phase) phase_q <= '0;
    else                 phase_q <= phase_q + 1'b1;
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST);
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LAST) |=> (phase_q == '0));
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_LAST) |=> (phase_q == PH_W'($past(phase_q) + 3'd1)));
endmodule

// File: rtl/fx_decode.sv
module fx_decode
  import fx_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output kind_e             kind,
  output logic [1:0]        length
);
  always_comb begin
    kind   = kind_of(opcode);
    length = len_of(kind);
  end
endmodule

// File: rtl/fx_bus_drive.sv
module fx_bus_drive
  import fx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [PH_W-1:0]   phase,
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] ip,
  input  logic [ADDR_W-1:0] mar,
  input  logic [BYTE_W-1:0] arg_lo,
  input  logic [BYTE_W-1:0] arg_hi,
  input  logic [BYTE_W-1:0] acc_lo,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              rw,
  output logic              act
);
  function automatic logic [ADDR_W-1:0] widen(input logic [BYTE_W-1:0] b);
    return ADDR_W'(b);
  endfunction

  logic has_args;
  logic has_mem_op;

  assign has_args   = (kind != K_NOP);
  assign has_mem_op = (kind == K_ADDM) || (kind == K_IND);
  assign wdata      = acc_lo;

  always_comb begin
    addr = ip;
    rw   = 1'b1;
    act  = 1'b0;
    case (phase)
      PH_FETCH: begin
        act  = 1'b1;
        addr = ip;
      end
      PH_ARG1: begin
        act  = has_args;
        addr = ip + ADDR_W'(1);
      end
      PH_ARG2: begin
        act  = has_args;
        addr = (kind == K_IND) ? widen(arg_lo) : ip + ADDR_W'(2);
      end
      PH_EXEC: begin
        act  = has_mem_op;
        addr = has_mem_op ? mar : ip;
      end
      PH_STORE: begin
        act  = has_mem_op;
        rw   = !has_mem_op;
        addr = (kind == K_ADDM) ? widen(arg_hi) : (kind == K_IND) ? mar : ip;
      end
      default: begin
        act  = 1'b0;
        addr = ip;
      end
    endcase
  end
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_rw,
  output logic              bus_act,
  output logic [15:0]       acc_o,
  output logic [2:0]        phase_o
);
  logic [PH_W-1:0]   phase;
  logic              last_phase;
  logic [ADDR_W-1:0] ip_q;
  logic [ADDR_W-1:0] mar_q;
  logic [BYTE_W-1:0] ir_q;
  logic [BYTE_W-1:0] arg_lo_q;
  logic [BYTE_W-1:0] arg_hi_q;
  logic [ACC_W-1:0]  acc_q;
  kind_e             kind;
  logic [1:0]        length;

  // named events for the assertions
  logic fetch_cycle;
  logic store_cycle;
  logic write_event;

  fx_phase_ctr u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .last_phase (last_phase)
  );

  fx_decode u_decode (
    .opcode (ir_q),
    .kind   (kind),
    .length (length)
  );

  fx_bus_drive #(.ADDR_W(ADDR_W)) u_bus (
    .phase  (phase),
    .kind   (kind),
    .ip     (ip_q),
    .mar    (mar_q),
    .arg_lo (arg_lo_q),
    .arg_hi (arg_hi_q),
    .acc_lo (acc_q[BYTE_W-1:0]),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rw     (bus_rw),
    .act    (bus_act)
  );

  assign fetch_cycle = (phase == PH_FETCH);
  assign store_cycle = last_phase;
  assign write_event = bus_act && !bus_rw;
  assign acc_o       = acc_q;
  assign phase_o     = phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q     <= '0;
      mar_q    <= '0;
      ir_q     <= '0;
      arg_lo_q <= '0;
      arg_hi_q <= '0;
      acc_q    <= '0;
    end else begin
      case (phase)
        PH_FETCH: ir_q <= bus_rdata;
        PH_ARG1: begin
          if (kind == K_ADDM)                     mar_q    <= ADDR_W'(bus_rdata);
          else if (kind == K_LDI || kind == K_IND) arg_lo_q <= bus_rdata;
        end
        PH_ARG2: begin
          if (kind == K_IND)                        mar_q    <= ADDR_W'(bus_rdata);
          else if (kind == K_LDI || kind == K_ADDM) arg_hi_q <= bus_rdata;
        end
        PH_EXEC: begin
          if (kind == K_LDI)                        acc_q <= imm_join(arg_lo_q, arg_hi_q);
          else if (kind == K_ADDM || kind == K_IND) acc_q <= acc_add(acc_q, bus_rdata);
        end
        PH_STORE: ip_q <= ip_q + ADDR_W'(length);
        default: ;
      endcase
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (ip_q == '0 && phase == PH_FETCH && acc_q == '0));
  assert_fetch_reads_ip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cycle |-> (bus_act && bus_rw && bus_addr == ip_q));
  assert_opcode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_cycle |=> $stable(ir_q));
  assert_ip_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !store_cycle |=> $stable(ip_q));
  assert_acc_only_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_EXEC) |=> $stable(acc_q));
  assert_write_in_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    write_event |-> store_cycle);
endmodule

// File: tb/test_fx_sequencer.sv
module test_fx_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int MEM_N = 1 << AW;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mem [MEM_N];
  logic [7:0] bus_rdata;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_rw, bus_act;
  logic [15:0] acc_o;
  logic [2:0] phase_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_ip;
  logic [15:0] exp_acc;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_rdata = mem[bus_addr];

  fx_sequencer #(.ADDR_W(AW)) i_fx_sequencer (
    .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rw(bus_rw), .bus_act(bus_act),
    .acc_o(acc_o), .phase_o(phase_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_bus(input int ph, input bit act, input bit rw,
                         input logic [7:0] addr, input string req);
    chk(phase_o == 3'(ph), "R2 phase", int'(phase_o), ph);
    chk(bus_act == act, {req, " act"}, int'(bus_act), int'(act));
    if (act) begin
      chk(bus_rw == rw, {req, " rw"}, int'(bus_rw), int'(rw));
      chk(bus_addr == addr, {req, " addr"}, int'(bus_addr), int'(addr));
    end else begin
      chk(bus_rw == 1'b1, "R9 idle no write", int'(bus_rw), 1);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // called at a falling edge inside microcycle 0
  task automatic do_instr(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] ip1, ip2, tgt, val, wd;
    logic [15:0] nacc;
    int len;
    ip1 = exp_ip + 8'd1;
    ip2 = exp_ip + 8'd2;
    mem[exp_ip] = op;
    mem[ip1] = b1;
    mem[ip2] = b2;
    #1;
    exp_bus(0, 1, 1, exp_ip, "R3 fetch");
    chk(acc_o == exp_acc, "R5 acc carried", int'(acc_o), int'(exp_acc));
    tgt = mem[b1];
    if (op == 8'hB8) begin
      nacc = {b2, b1}; len = 3;
      step(); exp_bus(1, 1, 1, ip1, "R4 imm lo");
      step(); exp_bus(2, 1, 1, ip2, "R4 imm hi");
      step(); exp_bus(3, 0, 1, exp_ip, "R4 idle");
      step(); exp_bus(4, 0, 1, exp_ip, "R4 idle");
      chk(acc_o == nacc, "R4 acc", int'(acc_o), int'(nacc));
    end else if (op == 8'h01) begin
      val = mem[b1]; nacc = exp_acc + {8'h00, val}; wd = nacc[7:0]; len = 3;
      step(); exp_bus(1, 1, 1, ip1, "R5 src byte");
      step(); exp_bus(2, 1, 1, ip2, "R5 dst byte");
      step(); exp_bus(3, 1, 1, b1, "R5 operand read");
      step(); exp_bus(4, 1, 0, b2, "R5 store");
      chk(acc_o == nacc, "R5 acc", int'(acc_o), int'(nacc));
      chk(bus_wdata == wd, "R5 wdata", int'(bus_wdata), int'(wd));
      mem[bus_addr] = bus_wdata;
    end else if (op == 8'h03) begin
      val = mem[tgt]; nacc = exp_acc + {8'h00, val}; wd = nacc[7:0]; len = 2;
      step(); exp_bus(1, 1, 1, ip1, "R6 pointer byte");
      step(); exp_bus(2, 1, 1, b1, "R6 address read");
      step(); exp_bus(3, 1, 1, tgt, "R6 operand read");
      step(); exp_bus(4, 1, 0, tgt, "R6 store");
      chk(acc_o == nacc, "R6 acc", int'(acc_o), int'(nacc));
      chk(bus_wdata == wd, "R6 wdata", int'(bus_wdata), int'(wd));
      mem[bus_addr] = bus_wdata;
    end else begin
      nacc = exp_acc; len = 1;
      for (int p = 1; p < 5; p++) begin
        step(); exp_bus(p, 0, 1, exp_ip, "R8 idle");
      end
      chk(acc_o == nacc, "R8 acc kept", int'(acc_o), int'(nacc));
    end
    step();
    exp_ip = exp_ip + 8'(len);
    exp_acc = nacc;
    chk(bus_addr == exp_ip, "R7 next ip", int'(bus_addr), int'(exp_ip));
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    exp_ip = 8'h00;
    exp_acc = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(acc_o == 16'h0, "R1 acc", int'(acc_o), 0);
    chk(phase_o == 3'd0, "R1 phase", int'(phase_o), 0);
    chk(bus_addr == 8'h00, "R1 ip", int'(bus_addr), 0);

    // R4 immediate loads
    for (int k = 0; k < 64; k++) begin
      logic [15:0] imm;
      imm = 16'(k * 1031 + 7);
      if (k == 0) imm = 16'h0100;
      do_instr(8'hB8, imm[7:0], imm[15:8]);
    end
    // R5 memory add and store
    for (int k = 0; k < 40; k++) begin
      logic [7:0] src, dst;
      src = exp_ip + 8'(100 + (k % 50));
      dst = exp_ip + 8'd160;
      mem[src] = 8'(k * 37 + 5);
      if (k == 0) mem[src] = 8'hFF;
      do_instr(8'h01, src, dst);
    end
    // R6 indirect add
    for (int k = 0; k < 16; k++) begin
      logic [7:0] ptr, tgt;
      ptr = exp_ip + 8'd60;
      tgt = exp_ip + 8'(200 + k);
      mem[ptr] = tgt;
      mem[tgt] = 8'(k * 53 + 11);
      do_instr(8'h03, ptr, 8'hA5);
    end
    // R8 every other opcode value
    for (int op = 0; op < 256; op++) begin
      if (op != 8'hB8 && op != 8'h01 && op != 8'h03)
        do_instr(8'(op), 8'h01, 8'h01);
    end
    do_instr(8'hB8, 8'h34, 8'h12);

    // R1 reset in the middle of an instruction
    mem[exp_ip] = 8'hB8;
    step(); step();
    chk(phase_o == 3'd2, "R2 before reset", int'(phase_o), 2);
    rst_n = 1'b0;
    step();
    chk(phase_o == 3'd0, "R1 mid reset phase", int'(phase_o), 0);
    chk(acc_o == 16'h0, "R1 mid reset acc", int'(acc_o), 0);
    chk(bus_addr == 8'h00, "R1 mid reset ip", int'(bus_addr), 0);
    rst_n = 1'b1;
    step();
    chk(phase_o == 3'd1, "R2 after reset", int'(phase_o), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule